// File: doc/BRIEF.md
# Sixteen-Register Stored-Program Core

This block is a small processor that runs a compact 16-bit instruction set. Instructions and data share one 256-word memory. The core has sixteen 16-bit general-purpose registers. Each instruction is fetched from memory into an instruction register, then decoded and executed. The core then returns to fetch, either at the next address or at a jump target. Arithmetic uses three register operands or one register and a signed 8-bit constant. Control flow uses an unconditional jump and four jumps that compare a register against zero.

Input and output are instructions that stall the core. A read waits for a valid word from the input side. A write holds a word on the output side until the receiver accepts it. The memory is filled through a separate load port while reset is held. When reset is released, execution begins at address 0 and runs until a halt word, which freezes the core and raises a status flag.

Top module: `stored_prog_core`

## Requirements
- R1: While `rst` is high, `halted`, `div_err`, `in_ready` and `out_valid` are all 0. After `rst` falls, the first instruction executed is the one at address 0.
- R2: A three-register word is {op[15:12], dest[11:8], srcA[7:4], srcB[3:0]}. Op 6 computes dest = srcA + srcB, op 7 computes srcA - srcB and op 8 computes srcA * srcB. All three keep the low 16 bits of the two's-complement result.
- R3: Op 9 computes the signed quotient srcA / srcB, truncated toward zero. Op 10 computes the signed remainder, which takes the sign of srcA.
- R4: When op 9 or op 10 has a zero divisor, the destination receives 0. `div_err` is set and stays set until reset, and execution continues with the next instruction.
- R5: The word {1, rX, k[7:0]} loads the sign-extended k into rX. The word {5, rX, k[7:0]} adds the sign-extended k to rX.
- R6: Register r0 always reads as 0, and any write to r0 is discarded.
- R7: The word 0x0X01 reads into rX. The core raises `in_ready` and waits. On the first clock edge with `in_valid` and `in_ready` both high, it stores `in_data` into rX.
- R8: The word 0x0X02 writes rX. The core drives rX on `out_data` with `out_valid` high, and holds both unchanged until a clock edge where `out_ready` is high. It sends exactly one word per write instruction.
- R9: The word {11, x, n[7:0]} jumps to address n. The words {12, rX, n}, {13, rX, n}, {14, rX, n} and {15, rX, n} jump to n when rX is zero, nonzero, positive or negative respectively. Otherwise execution continues at the next address.
- R10: The all-zero word halts the core. `halted` then stays 1, no further instruction runs, and `in_ready` and `out_valid` stay 0.
- R11: Words with op 2, 3 or 4 do nothing and advance to the next address. So do op-0 words other than halt, read and write.
- R12: With `load_en` high, `load_data` is written to memory address `load_addr` on the clock edge. This is intended while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Memory load strobe |
| load_addr | input | 8 | Memory load address |
| load_data | input | 16 | Memory load word |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Core waiting in a read |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word presented |
| out_ready | input | 1 | Receiver accepts output word |
| out_data | output | 16 | Output word |
| halted | output | 1 | Core has executed halt |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
Several properties are checked on every cycle:
- The halted state persists and stays silent.
- The divide-error flag is sticky.
- A pending output word holds steady under backpressure.
- The core never waits on input and output at once.
- A nop advances the program counter by exactly one.

Arithmetic results, signed division rounding, the r0 rule, the taken and untaken sides of each conditional jump, and the treatment of undefined words appear only at the ports. Only the bench's programs show them, through the exact sequence of words written out under irregular input and output handshakes.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 8;
    localparam int SEL_W     = 4;
    localparam int NUM_REGS  = 1 << SEL_W;
    localparam int MEM_WORDS = 1 << ADDR_W;
    localparam int IMM_W     = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic [3:0] {
        OP_SYS  = 4'd0,
        OP_SETN = 4'd1,
        OP_ADDN = 4'd5,
        OP_ADD  = 4'd6,
        OP_SUB  = 4'd7,
        OP_MUL  = 4'd8,
        OP_DIV  = 4'd9,
        OP_MOD  = 4'd10,
        OP_JMP  = 4'd11,
        OP_JEQZ = 4'd12,
        OP_JNEZ = 4'd13,
        OP_JGTZ = 4'd14,
        OP_JLTZ = 4'd15
    } opcode_e;

    localparam logic [7:0] SYS_READ  = 8'h01;
    localparam logic [7:0] SYS_WRITE = 8'h02;

    typedef enum logic [3:0] {
        K_NOP, K_HALT, K_READ, K_WRITE, K_SETN, K_ADDN, K_ALU, K_JUMP, K_BRANCH
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_MOD
    } alu_op_e;

    typedef enum logic [1:0] {
        C_ZERO, C_NONZERO, C_POS, C_NEG
    } cond_e;

    typedef enum logic [2:0] {
        S_FETCH, S_EXEC, S_IN, S_OUT, S_HALT
    } state_e;

    typedef struct packed {
        kind_e      kind;
        alu_op_e    alu_op;
        cond_e      cond;
        sel_t       rd;
        sel_t       rs1;
        sel_t       rs2;
        logic [IMM_W-1:0] imm;
    } dec_t;

    function automatic word_t sext_imm(logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic cond_holds(cond_e c, word_t v);
        logic z;
        logic n;
        z = (v == '0);
        n = v[WORD_W-1];
        case (c)
            C_ZERO:    return z;
            C_NONZERO: return !z;
            C_POS:     return !z && !n;
            default:   return n;
        endcase
    endfunction
endpackage

// File: rtl/spc_decode.sv
module spc_decode
    import spc_pkg::*;
(
    input  word_t word_i,
    output dec_t  dec_o
);
    always_comb begin
        dec_o        = '0;
        dec_o.kind   = K_NOP;
        dec_o.alu_op = ALU_ADD;
        dec_o.cond   = C_ZERO;
        dec_o.rd     = word_i[11:8];
        dec_o.rs1    = word_i[7:4];
        dec_o.rs2    = word_i[3:0];
        dec_o.imm    = word_i[7:0];
        case (word_i[15:12])
            OP_SYS: begin
                if (word_i == '0)                      dec_o.kind = K_HALT;
                else if (word_i[7:0] == SYS_READ)      dec_o.kind = K_READ;
                else if (word_i[7:0] == SYS_WRITE)     dec_o.kind = K_WRITE;
                else                                   dec_o.kind = K_NOP;
            end
            OP_SETN: dec_o.kind = K_SETN;
            OP_ADDN: dec_o.kind = K_ADDN;
            OP_ADD:  begin dec_o.kind = K_ALU; dec_o.alu_op = ALU_ADD; end
            OP_SUB:  begin dec_o.kind = K_ALU; dec_o.alu_op = ALU_SUB; end
            OP_MUL:  begin dec_o.kind = K_ALU; dec_o.alu_op = ALU_MUL; end
            OP_DIV:  begin dec_o.kind = K_ALU; dec_o.alu_op = ALU_DIV; end
            OP_MOD:  begin dec_o.kind = K_ALU; dec_o.alu_op = ALU_MOD; end
            OP_JMP:  dec_o.kind = K_JUMP;
            OP_JEQZ: begin dec_o.kind = K_BRANCH; dec_o.cond = C_ZERO;    end
            OP_JNEZ: begin dec_o.kind = K_BRANCH; dec_o.cond = C_NONZERO; end
            OP_JGTZ: begin dec_o.kind = K_BRANCH; dec_o.cond = C_POS;     end
            OP_JLTZ: begin dec_o.kind = K_BRANCH; dec_o.cond = C_NEG;     end
            default: dec_o.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/spc_regfile.sv
module spc_regfile #(
    parameter int NREGS = 16,
    parameter int W     = 16,
    localparam int SW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [SW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_flop
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (we && waddr == SW'(i))
                    regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/spc_alu.sv
module spc_alu
    import spc_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y,
    output logic    div_zero
);
    always_comb begin
        div_zero = (b == '0);
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;
            ALU_DIV: y = div_zero ? '0 : word_t'($signed(a) / $signed(b));
            ALU_MOD: y = div_zero ? '0 : word_t'($signed(a) % $signed(b));
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/stored_prog_core.sv
module stored_prog_core
    import spc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_en,
    input  logic [7:0]  load_addr,
    input  logic [15:0] load_data,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_data,
    output logic        halted,
    output logic        div_err
);
    state_e state;
    addr_t  pc;
    addr_t  pc_inc;
    word_t  ir;
    dec_t   dec;
    word_t  mem [MEM_WORDS];

    word_t  rdata_a, rdata_b, alu_y, wdata;
    logic   div_zero, we, taken;
    sel_t   raddr_a;

    // program/data memory, filled through the load port
    always_ff @(posedge clk) begin
        if (load_en)
            mem[load_addr] <= load_data;
    end

    spc_decode u_dec (
        .word_i (ir),
        .dec_o  (dec)
    );

    assign raddr_a = (dec.kind == K_ALU) ? dec.rs1 : dec.rd;

    spc_regfile #(.NREGS(NUM_REGS), .W(WORD_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .waddr   (dec.rd),
        .wdata   (wdata),
        .raddr_a (raddr_a),
        .rdata_a (rdata_a),
        .raddr_b (dec.rs2),
        .rdata_b (rdata_b)
    );

    spc_alu u_alu (
        .op       (dec.alu_op),
        .a        (rdata_a),
        .b        (rdata_b),
        .y        (alu_y),
        .div_zero (div_zero)
    );

    assign pc_inc   = pc + addr_t'(1);
    assign taken    = cond_holds(dec.cond, rdata_a);
    assign in_ready = (state == S_IN);

    always_comb begin
        we    = 1'b0;
        wdata = alu_y;
        if (state == S_IN) begin
            we    = in_valid;
            wdata = in_data;
        end else if (state == S_EXEC) begin
            case (dec.kind)
                K_SETN: begin we = 1'b1; wdata = sext_imm(dec.imm); end
                K_ADDN: begin we = 1'b1; wdata = rdata_a + sext_imm(dec.imm); end
                K_ALU:  begin we = 1'b1; wdata = alu_y; end
                default: we = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_FETCH;
            pc        <= '0;
            ir        <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            halted    <= 1'b0;
            div_err   <= 1'b0;
        end else begin
            case (state)
                S_FETCH: begin
                    ir    <= mem[pc];
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    state <= S_FETCH;
                    pc    <= pc_inc;
                    case (dec.kind)
                        K_HALT: begin
                            state  <= S_HALT;
                            halted <= 1'b1;
                            pc     <= pc;
                        end
                        K_READ: begin
                            state <= S_IN;
                            pc    <= pc;
                        end
                        K_WRITE: begin
                            state     <= S_OUT;
                            out_valid <= 1'b1;
                            out_data  <= rdata_a;
                            pc        <= pc;
                        end
                        K_JUMP:   pc <= dec.imm;
                        K_BRANCH: pc <= taken ? dec.imm : pc_inc;
                        K_ALU: begin
                            if (div_zero && (dec.alu_op == ALU_DIV || dec.alu_op == ALU_MOD))
                                div_err <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                S_IN: begin
                    if (in_valid) begin
                        pc    <= pc_inc;
                        state <= S_FETCH;
                    end
                end
                S_OUT: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        pc        <= pc_inc;
                        state     <= S_FETCH;
                    end
                end
                default: state <= S_HALT;
            endcase
        end
    end

    // R10: once halted, the core stays halted
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R10: a halted core performs no handshakes
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!in_ready && !out_valid));

    // R8: a pending output word holds until accepted
    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: divide error flag is sticky
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        div_err |=> div_err);

    // R7: never waiting on input and output at once
    p_io_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R11: a nop moves to the next address
    p_nop_step_r11: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && dec.kind == K_NOP) |=> (pc == $past(pc) + addr_t'(1)));
endmodule

// File: tb/tb_stored_prog_core.sv
`timescale 1ns/1ps
module tb_stored_prog_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        halted;
    logic        div_err;

    always #2.5 clk = ~clk;

    stored_prog_core dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .halted(halted), .div_err(div_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [15:0] prog_q[$];
    logic [15:0] in_q[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_out(logic [15:0] v, string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // driver of the handshake inputs and scoreboard monitor of outputs
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = (cyc % 4) != 1;
            in_valid  = (in_q.size() > 0) && ((cyc % 5) >= 2);
            in_data   = (in_q.size() > 0) ? in_q[0] : 16'h0;
            #1;
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected output word", out_data, 16'hxxxx);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data === e, t, out_data, e);
                end
            end
            if (!rst && in_valid && in_ready)
                void'(in_q.pop_front());
        end
    end

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog expired", 16'h0, 16'h0);
        finish_run();
    end

    task automatic run_prog(string name, bit exp_err);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < prog_q.size(); i++) begin
            load_en   = 1'b1;
            load_addr = 8'(i);
            load_data = prog_q[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!halted && !div_err && !in_ready && !out_valid, {"R1 reset outputs ", name},
            {12'h0, halted, div_err, in_ready, out_valid}, 16'h0);
        rst = 1'b0;
        for (int k = 0; k < 5000 && !halted; k++) @(negedge clk);
        repeat (12) @(negedge clk);
        // R10: halted and silent
        chk(halted === 1'b1, {"R10 halted ", name}, {15'h0, halted}, 16'h1);
        chk(!in_ready && !out_valid, {"R10 quiet after halt ", name},
            {14'h0, in_ready, out_valid}, 16'h0);
        chk(exp_q.size() == 0, {"R8 missing outputs ", name}, 16'(exp_q.size()), 16'h0);
        chk(in_q.size() == 0, {"R7 unconsumed inputs ", name}, 16'(in_q.size()), 16'h0);
        // R4: divide error flag
        chk(div_err === exp_err, {"R4 div_err ", name}, {15'h0, div_err}, {15'h0, exp_err});
        exp_q.delete(); tag_q.delete(); in_q.delete(); prog_q.delete();
    endtask

    task automatic load_square_plus(logic [15:0] x, logic [15:0] r);
        // R2 R7 R8 R12: read, square, add, write
        prog_q = '{16'h0101, 16'h8211, 16'h6221, 16'h0202, 16'h0000};
        in_q.push_back(x);
        expect_out(r, "R2 x*x+x");
    endtask

    task automatic load_factorial(logic [15:0] x, logic [15:0] r);
        // R5 R9: loop with jeqzn, addn -1, jumpn
        prog_q = '{16'h0101, 16'h1201, 16'hC106, 16'h8221,
                   16'h51FF, 16'hB002, 16'h0202, 16'h0000};
        in_q.push_back(x);
        expect_out(r, "R9 factorial loop");
    endtask

    initial begin
        load_square_plus(16'd6, 16'd42);
        run_prog("sq6", 1'b0);
        load_square_plus(16'hFFFD, 16'd6);
        run_prog("sq-3", 1'b0);
        load_factorial(16'd5, 16'd120);
        run_prog("fact5", 1'b0);
        load_factorial(16'd0, 16'd1);
        run_prog("fact0", 1'b0);
        load_factorial(16'd7, 16'd5040);
        run_prog("fact7", 1'b0);

        // arithmetic program
        prog_q = '{16'h1164, 16'h1207, 16'hA412, 16'h9314, 16'h7332, 16'h53FF,
                   16'h0302, 16'h0402,
                   16'h15F9, 16'h1602, 16'h9756, 16'hA856, 16'h0702, 16'h0802,
                   16'h9910, 16'h0902,
                   16'h1005, 16'h6011, 16'h0002,
                   16'h1A7F, 16'h8BAA, 16'h8BBA, 16'h0B02,
                   16'h1C80, 16'h0C02, 16'h0000};
        expect_out(16'd42,   "R3 100/(100%7)-7-1");
        expect_out(16'd2,    "R3 100%7");
        expect_out(16'hFFFD, "R3 -7/2 truncates");
        expect_out(16'hFFFF, "R3 -7%2 sign of dividend");
        expect_out(16'h0000, "R4 divide by zero gives 0");
        expect_out(16'h0000, "R6 r0 reads zero");
        expect_out(16'd16767,"R2 multiply wraps");
        expect_out(16'hFF80, "R5 setn -128 sign extends");
        run_prog("arith", 1'b1);

        // jump and nop program
        prog_q = '{16'h11FF, 16'hF103, 16'h0102, 16'hE105, 16'h1209, 16'hD207,
                   16'h0000, 16'hC009, 16'h0102, 16'h0202,
                   16'h2123, 16'h0300, 16'h4FFF, 16'h0005, 16'h3A01,
                   16'h0202, 16'h0000};
        expect_out(16'd9, "R9 branch outcomes");
        expect_out(16'd9, "R11 undefined words are nops");
        run_prog("jumps", 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule